// File: doc/BRIEF.md
# Opcode Fetch Sequencer with Halt State

This block generates the opcode-fetch machine cycle of an 8-bit processor front end and models the halted state with the correct address behaviour. Each machine cycle has four T-states. The block runs on a clock at twice the T-state rate, so one machine cycle takes eight clocks, called phases 0 to 7 (phase 0 is the first half of T1). In every cycle it drives the fetch address and the active-low strobes, samples one opcode byte from the data bus, and then presents a refresh address while the refresh strobe is low.

Opcodes fall into two classes: the halt opcode (0x76) and everything else. Any opcode other than 0x76 acts as a one-cycle instruction that steps the program counter. The halt opcode also steps the program counter past itself, and it then enters the halted state. While halted, the block keeps running real fetch cycles from the address after the halt byte. It throws the fetched byte away and does not move the program counter. An accepted maskable interrupt ends the halted state. Execution then continues from that same address, with no further increment. A one-clock pulse marks each acceptance. The 7-bit refresh counter steps once per machine cycle, including the discarded fetches.

Top module: `opfetch_halt_seq`

## Requirements
- R1: While rst_ni is low: addr_o is 0x0000, m1_no, mreq_no, rd_no, rfsh_no and halt_no are all 1, and int_ack_o is 0. The first clock phase after release is phase 0, and the first fetch reads address 0x0000.
- R2: m1_no, mreq_no and rd_no are low in phases 2, 3 and 4 and high in the other phases. In phases 0 to 4, addr_o carries the program counter.
- R3: rfsh_no is low in phases 5, 6 and 7 and high in phases 0 to 4. rfsh_no is never low while rd_no, mreq_no or m1_no is low. In phases 5 to 7, addr_o is {8'h00, R}, where R is the refresh counter value from before that cycle's increment.
- R4: The opcode is sampled on the rising edge that ends phase 4. If the byte is not 0x76 and the block is not halted, the next cycle fetches from the program counter plus one.
- R5: When opcode 0x76 is fetched outside the halted state, halt_no goes low at the start of the next cycle, and that cycle fetches from the address after the halt byte.
- R6: While halted, every cycle is a full fetch (rd_no low in phases 2 to 4) from the same address. The program counter does not change, and the fetched byte is ignored.
- R7: R bits 6:0 increment by one on the edge that ends phase 5 of every cycle, halted or not, and wrap from 0x7F to 0x00. R bit 7 keeps its value, which is 0 after reset. R is zero at reset.
- R8: An interrupt is accepted on the edge that ends phase 7 when int_en_i is 1 and irq_ni is 0. int_ack_o is then high for phase 0 of the next cycle only, halt_no returns high in that same phase, and that cycle fetches from the unchanged program counter.
- R9: While int_en_i is 0, a low irq_ni has no effect: int_ack_o stays 0 and a halted block stays halted at the same fetch address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at twice the T-state rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Data bus, read as the opcode |
| irq_ni | input | 1 | Maskable interrupt request, active low |
| int_en_i | input | 1 | Interrupt enable flag |
| addr_o | output | 16 | Fetch or refresh address |
| m1_no | output | 1 | Opcode-fetch cycle strobe, active low |
| mreq_no | output | 1 | Memory request strobe, active low |
| rd_no | output | 1 | Read strobe, active low |
| rfsh_no | output | 1 | Refresh strobe, active low |
| halt_no | output | 1 | Halted state indicator, active low |
| int_ack_o | output | 1 | One-clock pulse on interrupt acceptance |

## Verification
The strobes are decoded from the phase register, so each strobe changes in the same clock as the phase it belongs to. The bench keeps its own phase count, reset together with the design, and samples on the falling edge in the phase under test. The opcode takes effect at the end of phase 7, so a new fetch address or a change in halt_no is checked in phase 0 or phase 3 of the next cycle. The refresh address shows R from before the increment, so the bench checks it in phase 5 against the number of cycles since reset, modulo 128. An interrupt request is held across the edge that ends phase 7, and the acknowledge pulse is checked in phase 0 of the following cycle and again one clock later, when it must be low.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int unsigned PH_W = 3;
  localparam logic [PH_W-1:0] PH_STB_FIRST = 3'd2;
  localparam logic [PH_W-1:0] PH_STB_LAST  = 3'd4;
  localparam logic [PH_W-1:0] PH_SAMPLE    = 3'd4;
  localparam logic [PH_W-1:0] PH_RF_FIRST  = 3'd5;
  localparam logic [PH_W-1:0] PH_RINC      = 3'd5;
  localparam logic [PH_W-1:0] PH_END       = 3'd7;
endpackage

// File: rtl/opf_phase_ctr.sv
module opf_phase_ctr
  import opf_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] ph_o,
  output logic            samp_o,
  output logic            rinc_o,
  output logic            cyc_end_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= '0;
    else if (ph_q == PH_END)  ph_q <= '0;
    else                      ph_q <= ph_q + PH_W'(1);
  end

  assign ph_o      = ph_q;
  assign samp_o    = (ph_q == PH_SAMPLE);
  assign rinc_o    = (ph_q == PH_RINC);
  assign cyc_end_o = (ph_q == PH_END);
endmodule

// File: rtl/opf_strobe_gen.sv
module opf_strobe_gen
  import opf_pkg::*;
(
  input  logic [PH_W-1:0] ph_i,
  output logic            m1_no,
  output logic            mreq_no,
  output logic            rd_no,
  output logic            rfsh_no,
  output logic            rf_act_o
);
  logic fetch_act;

  always_comb begin
    fetch_act = (ph_i >= PH_STB_FIRST) && (ph_i <= PH_STB_LAST);
    rf_act_o  = (ph_i >= PH_RF_FIRST);
  end

  assign m1_no   = ~fetch_act;
  assign mreq_no = ~fetch_act;
  assign rd_no   = ~fetch_act;
  assign rfsh_no = ~rf_act_o;
endmodule

// File: rtl/opf_halt_ctrl.sv
module opf_halt_ctrl #(
  parameter int unsigned     DATA_W  = 8,
  parameter logic [DATA_W-1:0] HALT_OP = 8'h76
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_end_i,
  input  logic [DATA_W-1:0] op_i,
  input  logic              irq_ni,
  input  logic              int_en_i,
  output logic              halted_o,
  output logic              int_ack_o,
  output logic              pc_inc_o
);
  logic halted_q, ack_q, irq_take;

  assign irq_take = cyc_end_i & int_en_i & ~irq_ni;
  // halted fetches are discarded: no PC step
  assign pc_inc_o = cyc_end_i & ~halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= irq_take;
      if (cyc_end_i) begin
        if (irq_take)             halted_q <= 1'b0;
        else if (op_i == HALT_OP) halted_q <= 1'b1;
      end
    end
  end

  assign halted_o  = halted_q;
  assign int_ack_o = ack_q;
endmodule

// File: rtl/opf_datapath.sv
module opf_datapath #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned R_CNT_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic              rinc_i,
  input  logic              pc_inc_i,
  input  logic              rf_act_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] op_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] r_o
);
  localparam int unsigned PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0]  pc_q;
  logic [DATA_W-1:0]  r_q, rf_lo_q, op_q;
  logic [R_CNT_W-1:0] r_cnt_nxt;

  assign r_cnt_nxt = r_q[R_CNT_W-1:0] + R_CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      r_q     <= '0;
      rf_lo_q <= '0;
      op_q    <= '0;
    end else begin
      if (samp_i) begin
        op_q    <= data_i;
        rf_lo_q <= r_q;   // refresh address holds pre-increment R
      end
      if (rinc_i)   r_q  <= {r_q[DATA_W-1:R_CNT_W], r_cnt_nxt};
      if (pc_inc_i) pc_q <= pc_q + ADDR_W'(1);
    end
  end

  assign addr_o = rf_act_i ? {{PAD_W{1'b0}}, rf_lo_q} : pc_q;
  assign op_o   = op_q;
  assign pc_o   = pc_q;
  assign r_o    = r_q;
endmodule

// File: rtl/opfetch_halt_seq.sv
module opfetch_halt_seq
  import opf_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 16,
  parameter int unsigned       DATA_W  = 8,
  parameter int unsigned       R_CNT_W = 7,
  parameter logic [DATA_W-1:0] HALT_OP = 8'h76
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              irq_ni,
  input  logic              int_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              m1_no,
  output logic              mreq_no,
  output logic              rd_no,
  output logic              rfsh_no,
  output logic              halt_no,
  output logic              int_ack_o
);
  logic [PH_W-1:0]   ph;
  logic              samp, rinc, cyc_end, rf_act, halted, pc_inc;
  logic [DATA_W-1:0] op_w, r_w;
  logic [ADDR_W-1:0] pc_w;

  opf_phase_ctr u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .ph_o(ph),
    .samp_o(samp), .rinc_o(rinc), .cyc_end_o(cyc_end)
  );

  opf_strobe_gen u_stb (
    .ph_i(ph), .m1_no(m1_no), .mreq_no(mreq_no), .rd_no(rd_no),
    .rfsh_no(rfsh_no), .rf_act_o(rf_act)
  );

  opf_halt_ctrl #(.DATA_W(DATA_W), .HALT_OP(HALT_OP)) u_halt (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_end_i(cyc_end), .op_i(op_w),
    .irq_ni(irq_ni), .int_en_i(int_en_i), .halted_o(halted),
    .int_ack_o(int_ack_o), .pc_inc_o(pc_inc)
  );

  opf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .R_CNT_W(R_CNT_W)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .samp_i(samp), .rinc_i(rinc),
    .pc_inc_i(pc_inc), .rf_act_i(rf_act), .data_i(data_i),
    .addr_o(addr_o), .op_o(op_w), .pc_o(pc_w), .r_o(r_w)
  );

  assign halt_no = ~halted;
endmodule

// File: rtl/opfetch_halt_chk.sv
module opfetch_halt_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned R_CNT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              m1_no,
  input logic              mreq_no,
  input logic              rd_no,
  input logic              rfsh_no,
  input logic              halt_no,
  input logic              int_ack_o,
  input logic              int_en_i,
  input logic              irq_ni,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] r_q
);
  localparam logic [R_CNT_W-1:0] R_ONE = R_CNT_W'(1);
  localparam logic [ADDR_W-1:0]  PC_ONE = ADDR_W'(1);

  assert_rfsh_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rfsh_no |-> (rd_no && mreq_no && m1_no));

  assert_r_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rfsh_no) |=> ((r_q[R_CNT_W-1:0] == $past(r_q[R_CNT_W-1:0]) + R_ONE)
                        && (r_q[DATA_W-1] == $past(r_q[DATA_W-1]))));

  assert_halt_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_no) |-> (pc_q == $past(pc_q) + PC_ONE));

  assert_halt_pc_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_no && !$past(halt_no)) |-> $stable(pc_q));

  assert_ack_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_o |-> ($past(int_en_i) && !$past(irq_ni) && halt_no));

  assert_ack_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_o |=> !int_ack_o);
endmodule

bind opfetch_halt_seq opfetch_halt_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .R_CNT_W(R_CNT_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .m1_no(m1_no), .mreq_no(mreq_no),
  .rd_no(rd_no), .rfsh_no(rfsh_no), .halt_no(halt_no),
  .int_ack_o(int_ack_o), .int_en_i(int_en_i), .irq_ni(irq_ni),
  .pc_q(pc_w), .r_q(r_w)
);

// File: tb/opfetch_halt_seq_tb_top.sv
`timescale 1ns/1ps
module opfetch_halt_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data;
  logic        irq_n = 1'b1;
  logic        int_en = 1'b0;
  logic [15:0] addr;
  logic        m1_n, mreq_n, rd_n, rfsh_n, halt_n, int_ack;
  logic [15:0] halt_addr = 16'hFFFF;
  logic [2:0]  tb_ph;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  // memory model: 0x76 at halt_addr, 0xC5 after it, 0x00 elsewhere
  always_comb begin
    if (addr == halt_addr)              data = 8'h76;
    else if (addr == halt_addr + 16'd1) data = 8'hC5;
    else                                data = 8'h00;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_ph <= 3'd0;
    else        tb_ph <= tb_ph + 3'd1;
  end

  opfetch_halt_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .irq_ni(irq_n),
    .int_en_i(int_en), .addr_o(addr), .m1_no(m1_n), .mreq_no(mreq_n),
    .rd_no(rd_n), .rfsh_no(rfsh_n), .halt_no(halt_n), .int_ack_o(int_ack)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic to_phase(input logic [2:0] k);
    do @(negedge clk); while (tb_ph != k);
  endtask

  task automatic do_reset(input logic [15:0] ha);
    rst_n = 1'b0; irq_n = 1'b1; int_en = 1'b0; halt_addr = ha;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; irq_n = 1'b1; int_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "addr in reset", 32'(addr), 32'h0);
    chk("R1", "strobes in reset", {27'd0, m1_n, mreq_n, rd_n, rfsh_n, halt_n}, 32'h1F);
    chk("R1", "ack in reset", 32'(int_ack), 32'h0);
    do_reset(16'hFFFF);
    chk("R1", "first fetch addr", 32'(addr), 32'h0);
  endtask

  task automatic t_timing;
    do_reset(16'hFFFF);
    for (int c = 0; c < 2; c++) begin
      for (int p = 0; p < 8; p++) begin
        logic fe, rf;
        if (p != 0 || c != 0) to_phase(3'(p));
        fe = (p >= 2 && p <= 4);
        rf = (p >= 5);
        chk("R2", "m1/mreq/rd", {29'd0, m1_n, mreq_n, rd_n}, fe ? 32'h0 : 32'h7);
        chk("R3", "rfsh", 32'(rfsh_n), rf ? 32'h0 : 32'h1);
        chk(rf ? "R3" : "R2", "addr", 32'(addr), 32'(c));
      end
    end
  endtask

  task automatic t_run;
    do_reset(16'hFFFF);
    for (int n = 0; n < 200; n++) begin
      to_phase(3'd3);
      chk("R4", "fetch addr", 32'(addr), 32'(n));
      to_phase(3'd5);
      chk("R7", "refresh addr", 32'(addr), 32'(n % 128));
    end
  endtask

  task automatic t_halt;
    do_reset(16'h00FF);
    for (int i = 0; i < 256; i++) begin
      if (i == 255) chk("R5", "not halted during halt fetch", 32'(halt_n), 32'h1);
      to_phase(3'd0);
    end
    chk("R5", "halt_no after halt", 32'(halt_n), 32'h0);
    chk("R5", "addr after halt", 32'(addr), 32'h0100);
    for (int k = 0; k < 5; k++) begin
      if (k >= 2) begin irq_n = 1'b0; int_en = 1'b0; end
      to_phase(3'd3);
      chk("R6", "halted fetch addr", 32'(addr), 32'h0100);
      chk("R6", "halted rd_no", 32'(rd_n), 32'h0);
      to_phase(3'd5);
      chk("R7", "halted refresh addr", 32'(addr), 32'((256 + k) % 128));
      to_phase(3'd0);
      chk("R9", "still halted", 32'(halt_n), 32'h0);
      chk("R9", "no ack when masked", 32'(int_ack), 32'h0);
    end
    int_en = 1'b1; irq_n = 1'b0;
    to_phase(3'd0);
    chk("R8", "ack pulse", 32'(int_ack), 32'h1);
    chk("R8", "halt cleared", 32'(halt_n), 32'h1);
    chk("R8", "resume addr", 32'(addr), 32'h0100);
    irq_n = 1'b1; int_en = 1'b0;
    to_phase(3'd1);
    chk("R8", "ack one clock", 32'(int_ack), 32'h0);
    to_phase(3'd3);
    chk("R8", "resume fetch", 32'(addr), 32'h0100);
    to_phase(3'd5);
    chk("R7", "refresh after resume", 32'(addr), 32'(262 % 128));
    to_phase(3'd3);
    chk("R4", "step after resume", 32'(addr), 32'h0101);
  endtask

  initial begin
    t_reset();
    t_timing();
    t_run();
    t_halt();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule